// File: doc/BRIEF.md
# Trap entry and vectoring unit

This unit sits beside a 32-bit in-order core and performs the state changes that enter a trap. Four sources can request entry: a hardware exception, a memory-management fault, an external interrupt and a hardware break. Each cycle the unit looks at the requests, at the current machine status word and at the per-instruction flags for delay slot, pending immediate prefix and branch-with-immediate. It chooses at most one trap and, one cycle later, presents the new program counter, the link register to write with its return address, the updated status word and, for exceptions and faults, the new exception status, branch target save and faulting address values.

The core writes back whatever the unit presents in the cycle `trap_taken_o` is high. That pulse also tells the core to clear its instruction flags and to drop any load-reserved reservation. The core then redirects fetch to `pc_o`. The vector base is a parameter. A memory-management fault that arrives before the core has signalled the end of the previous fault entry does not enter a trap. Instead it raises a sticky double-fault output.

Top module: `trap_entry_unit`

## Requirements
- R1: While `rst` is high on a clock edge, every output is driven to zero at that edge.
- R2: Requests are resolved in a fixed priority: memory fault (kind 3) first, then hardware exception (kind 2), then break (kind 1), then interrupt (kind 0). The chosen trap appears on `trap_kind_o`, and `trap_taken_o` is high for exactly the cycle after the request cycle. The other outputs hold their values while no trap is taken.
- R3: An interrupt is taken only when `msr_i` bit 1 (interrupt enable) is 1, bit 9 (exception in progress) is 0, bit 3 (break in progress) is 0, and neither `dslot_i` nor `imm_i` is set.
- R4: `pc_o` is VEC_BASE+0x10 for an interrupt, VEC_BASE+0x18 for a break, and VEC_BASE+0x20 for a hardware exception or a memory fault.
- R5: An interrupt writes the request-cycle PC to link register 14 and clears `msr_o` bit 1.
- R6: A break writes the PC to link register 16 and sets `msr_o` bit 3.
- R7: A hardware exception writes PC+4 to link register 17, sets `msr_o` bit 9, and sets `esr_o` to `hwexc_cause_i` in bits 4:0 with all other bits zero except the delay-slot bit.
- R8: A memory fault sets `msr_o` bit 9 and writes to link register 17 one of four values. It writes PC-8 in a delay slot after a branch-with-immediate, PC-4 in any other delay slot, PC-4 after an immediate prefix, and PC in all other cases.
- R9: For hardware exceptions and memory faults, `esr_we_o` pulses and `esr_o` bit 12 equals `dslot_i`. `btr_we_o` pulses with `btr_o` = `btarget_i` only when `dslot_i` is set. Interrupts and breaks pulse neither write enable.
- R10: On every trap, `msr_o` bit 12 takes `msr_i` bit 11 (user mode) and bit 14 takes `msr_i` bit 13 (virtual memory). Bits 11 and 13 become 0, and all other bits not named in R5 to R8 pass through unchanged.
- R11: A memory fault puts one of four codes in `esr_o` bits 4:0. The code is 17 for a fetch protection fault, 16 for a data protection fault, 19 for a fetch miss and 18 for a data miss. `mmu_miss_i` = 1 marks a miss, and on `mmu_acc_i` 0 is fetch, 1 is load and 2 is store. Bit 10 is set for a store. `ear_we_o` pulses with `ear_o` = `mmu_addr_i`.
- R12: A memory fault entry starts a fault-busy state, which lasts until a cycle with `fault_done_i` high. A memory fault request while busy takes no trap at all that cycle and sets `dbl_fault_o`. `dbl_fault_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | XLEN | PC of the current instruction |
| btarget_i | input | XLEN | Pending branch target |
| dslot_i | input | 1 | Instruction is in a delay slot |
| imm_i | input | 1 | Instruction follows an immediate prefix |
| bimm_i | input | 1 | Delay-slot branch carried an immediate prefix |
| msr_i | input | XLEN | Current machine status word |
| hwexc_req_i | input | 1 | Hardware exception request |
| hwexc_cause_i | input | CAUSE_W | Hardware exception cause code |
| mmu_req_i | input | 1 | Memory fault request |
| mmu_miss_i | input | 1 | Fault is a miss (1) or protection (0) |
| mmu_acc_i | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| mmu_addr_i | input | XLEN | Faulting address |
| brk_req_i | input | 1 | Hardware break request |
| irq_req_i | input | 1 | External interrupt request |
| fault_done_i | input | 1 | Core has finished the current fault entry |
| trap_taken_o | output | 1 | One-cycle trap entry pulse |
| trap_kind_o | output | 2 | Kind of trap taken |
| pc_o | output | XLEN | Vector address |
| link_idx_o | output | RIDX_W | Register receiving the return address |
| link_data_o | output | XLEN | Return address |
| msr_o | output | XLEN | New status word |
| esr_we_o | output | 1 | Exception status write enable |
| esr_o | output | XLEN | New exception status |
| btr_we_o | output | 1 | Branch target save write enable |
| btr_o | output | XLEN | Saved branch target |
| ear_we_o | output | 1 | Faulting-address write enable |
| ear_o | output | XLEN | Faulting address |
| dbl_fault_o | output | 1 | Sticky double-fault flag |

## Verification
The bench goes after four corners of the fault return address: branch-with-immediate delay slot, plain delay slot, immediate prefix and none. A design that mixed them up would resume at the wrong instruction or skip the prefix. It tries each blocking condition of the interrupt gate on its own. A gate that missed one would take an interrupt inside a delay slot or a handler. All four requests are raised together to expose a wrong priority. A fault is sent while the previous fault is still busy and again right after `fault_done_i`. A design that re-entered, or that never left the busy state, would show up as a wrong pulse or a wrong `dbl_fault_o`. Random cycles also check that the mode bits shift into their shadow copies, and that outputs hold between traps.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    TK_IRQ   = 2'd0,
    TK_BRK   = 2'd1,
    TK_HWEXC = 2'd2,
    TK_MMU   = 2'd3
  } trap_kind_e;

  // status word bit positions (mode bits sit one below their shadow copies)
  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_UMS = 12;
  localparam int MSR_VM  = 13;
  localparam int MSR_VMS = 14;

  // exception status bit positions
  localparam int ESR_ST = 10;
  localparam int ESR_DS = 12;

  // fault codes
  localparam logic [4:0] EC_DPROT = 5'd16;
  localparam logic [4:0] EC_IPROT = 5'd17;
  localparam logic [4:0] EC_DMISS = 5'd18;
  localparam logic [4:0] EC_IMISS = 5'd19;

  // access types
  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd2;

  // link registers
  localparam int LR_IRQ = 14;
  localparam int LR_BRK = 16;
  localparam int LR_EXC = 17;

  // vector offsets
  localparam int VOFS_IRQ = 'h10;
  localparam int VOFS_BRK = 'h18;
  localparam int VOFS_EXC = 'h20;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic       mmu_req,
  input  logic       hwexc_req,
  input  logic       brk_req,
  input  logic       irq_req,
  input  logic       ie,
  input  logic       eip,
  input  logic       bip,
  input  logic       dslot,
  input  logic       imm,
  input  logic       busy,
  output logic       take,
  output trap_kind_e kind,
  output logic       dbl_hit
);
  logic irq_ok;

  assign irq_ok  = irq_req & ie & ~eip & ~bip & ~dslot & ~imm;
  assign dbl_hit = mmu_req & busy;

  always_comb begin
    take = 1'b0;
    kind = TK_IRQ;
    if (mmu_req) begin
      take = ~busy;
      kind = TK_MMU;
    end else if (hwexc_req) begin
      take = 1'b1;
      kind = TK_HWEXC;
    end else if (brk_req) begin
      take = 1'b1;
      kind = TK_BRK;
    end else if (irq_ok) begin
      take = 1'b1;
      kind = TK_IRQ;
    end
  end
endmodule

// File: rtl/trap_retaddr.sv
module trap_retaddr
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              RIDX_W   = 5,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  trap_kind_e        kind,
  input  logic [XLEN-1:0]   pc,
  input  logic              dslot,
  input  logic              imm,
  input  logic              bimm,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_data,
  output logic [XLEN-1:0]   vec
);
  localparam logic [XLEN-1:0] STEP  = XLEN'(4);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(8);

  logic [XLEN-1:0] fault_ret;

  always_comb begin
    if (dslot)    fault_ret = bimm ? pc - STEP2 : pc - STEP;
    else if (imm) fault_ret = pc - STEP;
    else          fault_ret = pc;
  end

  always_comb begin
    unique case (kind)
      TK_IRQ: begin
        link_idx  = RIDX_W'(LR_IRQ);
        link_data = pc;
        vec       = VEC_BASE + XLEN'(VOFS_IRQ);
      end
      TK_BRK: begin
        link_idx  = RIDX_W'(LR_BRK);
        link_data = pc;
        vec       = VEC_BASE + XLEN'(VOFS_BRK);
      end
      TK_HWEXC: begin
        link_idx  = RIDX_W'(LR_EXC);
        link_data = pc + STEP;
        vec       = VEC_BASE + XLEN'(VOFS_EXC);
      end
      default: begin
        link_idx  = RIDX_W'(LR_EXC);
        link_data = fault_ret;
        vec       = VEC_BASE + XLEN'(VOFS_EXC);
      end
    endcase
  end
endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  trap_kind_e         kind,
  input  logic [XLEN-1:0]    msr_cur,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               miss,
  input  logic [1:0]         acc,
  input  logic               dslot,
  output logic [XLEN-1:0]    msr_nxt,
  output logic [XLEN-1:0]    esr_nxt,
  output logic               esr_we
);
  logic [XLEN-1:0] m;
  logic [4:0]      fcode;

  always_comb begin
    m = msr_cur;
    unique case (kind)
      TK_IRQ:  m[MSR_IE]  = 1'b0;
      TK_BRK:  m[MSR_BIP] = 1'b1;
      default: m[MSR_EIP] = 1'b1;
    endcase
    m[MSR_UMS] = msr_cur[MSR_UM];
    m[MSR_VMS] = msr_cur[MSR_VM];
    m[MSR_UM]  = 1'b0;
    m[MSR_VM]  = 1'b0;
    msr_nxt    = m;
  end

  always_comb begin
    if (acc == ACC_FETCH) fcode = miss ? EC_IMISS : EC_IPROT;
    else                  fcode = miss ? EC_DMISS : EC_DPROT;
  end

  always_comb begin
    esr_nxt = '0;
    esr_we  = 1'b0;
    if (kind == TK_HWEXC) begin
      esr_we               = 1'b1;
      esr_nxt[CAUSE_W-1:0] = cause;
    end else if (kind == TK_MMU) begin
      esr_we         = 1'b1;
      esr_nxt[4:0]   = fcode;
      esr_nxt[ESR_ST] = (acc == ACC_STORE);
    end
    esr_nxt[ESR_DS] = esr_we & dslot;
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              RIDX_W   = 5,
  parameter int              CAUSE_W  = 5,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    btarget_i,
  input  logic               dslot_i,
  input  logic               imm_i,
  input  logic               bimm_i,
  input  logic [XLEN-1:0]    msr_i,
  input  logic               hwexc_req_i,
  input  logic [CAUSE_W-1:0] hwexc_cause_i,
  input  logic               mmu_req_i,
  input  logic               mmu_miss_i,
  input  logic [1:0]         mmu_acc_i,
  input  logic [XLEN-1:0]    mmu_addr_i,
  input  logic               brk_req_i,
  input  logic               irq_req_i,
  input  logic               fault_done_i,
  output logic               trap_taken_o,
  output logic [1:0]         trap_kind_o,
  output logic [XLEN-1:0]    pc_o,
  output logic [RIDX_W-1:0]  link_idx_o,
  output logic [XLEN-1:0]    link_data_o,
  output logic [XLEN-1:0]    msr_o,
  output logic               esr_we_o,
  output logic [XLEN-1:0]    esr_o,
  output logic               btr_we_o,
  output logic [XLEN-1:0]    btr_o,
  output logic               ear_we_o,
  output logic [XLEN-1:0]    ear_o,
  output logic               dbl_fault_o
);
  logic              take;
  trap_kind_e        kind;
  logic              dbl_hit;
  logic              fault_busy_q;
  logic [RIDX_W-1:0] link_idx_n;
  logic [XLEN-1:0]   link_data_n;
  logic [XLEN-1:0]   vec_n;
  logic [XLEN-1:0]   msr_n;
  logic [XLEN-1:0]   esr_n;
  logic              esr_we_n;

  trap_arbiter u_arb (
    .mmu_req   (mmu_req_i),
    .hwexc_req (hwexc_req_i),
    .brk_req   (brk_req_i),
    .irq_req   (irq_req_i),
    .ie        (msr_i[MSR_IE]),
    .eip       (msr_i[MSR_EIP]),
    .bip       (msr_i[MSR_BIP]),
    .dslot     (dslot_i),
    .imm       (imm_i),
    .busy      (fault_busy_q),
    .take      (take),
    .kind      (kind),
    .dbl_hit   (dbl_hit)
  );

  trap_retaddr #(.XLEN(XLEN), .RIDX_W(RIDX_W), .VEC_BASE(VEC_BASE)) u_ret (
    .kind      (kind),
    .pc        (pc_i),
    .dslot     (dslot_i),
    .imm       (imm_i),
    .bimm      (bimm_i),
    .link_idx  (link_idx_n),
    .link_data (link_data_n),
    .vec       (vec_n)
  );

  trap_status #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_st (
    .kind    (kind),
    .msr_cur (msr_i),
    .cause   (hwexc_cause_i),
    .miss    (mmu_miss_i),
    .acc     (mmu_acc_i),
    .dslot   (dslot_i),
    .msr_nxt (msr_n),
    .esr_nxt (esr_n),
    .esr_we  (esr_we_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_taken_o <= 1'b0;
      trap_kind_o  <= '0;
      pc_o         <= '0;
      link_idx_o   <= '0;
      link_data_o  <= '0;
      msr_o        <= '0;
      esr_we_o     <= 1'b0;
      esr_o        <= '0;
      btr_we_o     <= 1'b0;
      btr_o        <= '0;
      ear_we_o     <= 1'b0;
      ear_o        <= '0;
      dbl_fault_o  <= 1'b0;
      fault_busy_q <= 1'b0;
    end else begin
      trap_taken_o <= take;
      esr_we_o     <= take & esr_we_n;
      btr_we_o     <= take & esr_we_n & dslot_i;
      ear_we_o     <= take & (kind == TK_MMU);
      dbl_fault_o  <= dbl_fault_o | dbl_hit;
      if (take && kind == TK_MMU) fault_busy_q <= 1'b1;
      else if (fault_done_i)      fault_busy_q <= 1'b0;
      if (take) begin
        trap_kind_o <= kind;
        pc_o        <= vec_n;
        link_idx_o  <= link_idx_n;
        link_data_o <= link_data_n;
        msr_o       <= msr_n;
        if (esr_we_n)               esr_o <= esr_n;
        if (esr_we_n && dslot_i)    btr_o <= btarget_i;
        if (kind == TK_MMU)         ear_o <= mmu_addr_i;
      end
    end
  end
endmodule

// File: rtl/trap_entry_unit_chk.sv
module trap_entry_unit_chk
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              dslot_i,
  input logic              imm_i,
  input logic [XLEN-1:0]   msr_i,
  input logic              mmu_req_i,
  input logic              irq_req_i,
  input logic              hwexc_req_i,
  input logic              brk_req_i,
  input logic              fault_busy_q,
  input logic              trap_taken_o,
  input logic [1:0]        trap_kind_o,
  input logic [RIDX_W-1:0] link_idx_o,
  input logic [XLEN-1:0]   msr_o,
  input logic              esr_we_o,
  input logic [XLEN-1:0]   esr_o,
  input logic              btr_we_o,
  input logic              dbl_fault_o
);
  // R2
  mmu_first_chk: assert property (@(posedge clk) disable iff (rst)
    (mmu_req_i && !fault_busy_q) |=> (trap_taken_o && trap_kind_o == 2'd3));

  // R2
  no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (!mmu_req_i && !hwexc_req_i && !brk_req_i && !irq_req_i) |=> !trap_taken_o);

  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req_i && !mmu_req_i && !hwexc_req_i && !brk_req_i &&
     (!msr_i[MSR_IE] || msr_i[MSR_EIP] || msr_i[MSR_BIP] || dslot_i || imm_i))
    |=> !trap_taken_o);

  // R5
  irq_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_taken_o && trap_kind_o == 2'd0) |-> (!msr_o[MSR_IE] && link_idx_o == RIDX_W'(LR_IRQ)));

  // R9
  btr_ds_chk: assert property (@(posedge clk) disable iff (rst)
    btr_we_o |-> (esr_we_o && esr_o[ESR_DS]));

  // R10
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken_o |-> (!msr_o[MSR_UM] && !msr_o[MSR_VM]));

  // R12
  dbl_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    dbl_fault_o |=> dbl_fault_o);

  // R12
  dbl_block_chk: assert property (@(posedge clk) disable iff (rst)
    (mmu_req_i && fault_busy_q) |=> (!trap_taken_o && dbl_fault_o));
endmodule

bind trap_entry_unit trap_entry_unit_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (.*);

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VB = 32'h8000_0100;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc_i, btarget_i, msr_i, mmu_addr_i;
  logic        dslot_i, imm_i, bimm_i;
  logic        hwexc_req_i, mmu_req_i, mmu_miss_i, brk_req_i, irq_req_i, fault_done_i;
  logic [4:0]  hwexc_cause_i;
  logic [1:0]  mmu_acc_i;
  logic        trap_taken_o, esr_we_o, btr_we_o, ear_we_o, dbl_fault_o;
  logic [1:0]  trap_kind_o;
  logic [31:0] pc_o, link_data_o, msr_o, esr_o, btr_o, ear_o;
  logic [4:0]  link_idx_o;

  int errors = 0;
  int checks = 0;

  // model state
  logic        m_busy, m_dbl;
  logic [1:0]  e_kind;
  logic [31:0] e_pc, e_link, e_msr, e_esr, e_btr, e_ear;
  logic [4:0]  e_idx;

  trap_entry_unit #(.VEC_BASE(VB)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string ktag(input logic [1:0] k);
    case (k)
      2'd0: return "R5";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic idle_inputs();
    hwexc_req_i = 0; mmu_req_i = 0; brk_req_i = 0; irq_req_i = 0;
    fault_done_i = 0; dslot_i = 0; imm_i = 0; bimm_i = 0;
    mmu_miss_i = 0; mmu_acc_i = 0; hwexc_cause_i = 0;
  endtask

  task automatic step();
    logic irq_ok, take, wesr, wbtr, wear, dbl_now;
    logic [1:0] k;
    logic [31:0] pc_e, lnk, m, es;
    logic [4:0] idx;
    string gtag;
    irq_ok = irq_req_i & msr_i[1] & ~msr_i[9] & ~msr_i[3] & ~dslot_i & ~imm_i;
    take = 1; k = 0; dbl_now = 0;
    gtag = "R2";
    if (mmu_req_i) begin
      k = 3;
      if (m_busy) begin take = 0; dbl_now = 1; gtag = "R12"; end
    end else if (hwexc_req_i) k = 2;
    else if (brk_req_i) k = 1;
    else if (irq_ok) k = 0;
    else begin take = 0; if (irq_req_i) gtag = "R3"; end
    case (k)
      2'd0: begin pc_e = VB + 32'h10; idx = 14; lnk = pc_i; end
      2'd1: begin pc_e = VB + 32'h18; idx = 16; lnk = pc_i; end
      2'd2: begin pc_e = VB + 32'h20; idx = 17; lnk = pc_i + 4; end
      default: begin
        pc_e = VB + 32'h20; idx = 17;
        lnk = dslot_i ? (bimm_i ? pc_i - 8 : pc_i - 4) : (imm_i ? pc_i - 4 : pc_i);
      end
    endcase
    m = msr_i;
    if (k == 0) m[1] = 0; else if (k == 1) m[3] = 1; else m[9] = 1;
    m[12] = msr_i[11]; m[14] = msr_i[13]; m[11] = 0; m[13] = 0;
    es = 0;
    if (k == 2) es[4:0] = hwexc_cause_i;
    if (k == 3) begin
      es[4:0] = (mmu_acc_i == 0) ? (mmu_miss_i ? 5'd19 : 5'd17) : (mmu_miss_i ? 5'd18 : 5'd16);
      es[10] = (mmu_acc_i == 2);
    end
    es[12] = dslot_i;
    wesr = take & (k >= 2);
    wbtr = wesr & dslot_i;
    wear = take & (k == 3);
    @(posedge clk); #1;
    if (take) begin
      e_kind = k; e_pc = pc_e; e_idx = idx; e_link = lnk; e_msr = m;
      if (wesr) e_esr = es;
      if (wbtr) e_btr = btarget_i;
      if (wear) e_ear = mmu_addr_i;
    end
    if (take && k == 3) m_busy = 1; else if (fault_done_i) m_busy = 0;
    m_dbl = m_dbl | dbl_now;
    chk(trap_taken_o == take, gtag, "trap_taken", 32'(trap_taken_o), 32'(take));
    chk(trap_kind_o == e_kind, "R2", "kind", 32'(trap_kind_o), 32'(e_kind));
    chk(pc_o == e_pc, "R4", "pc", pc_o, e_pc);
    chk(link_idx_o == e_idx, ktag(e_kind), "link_idx", 32'(link_idx_o), 32'(e_idx));
    chk(link_data_o == e_link, ktag(e_kind), "link_data", link_data_o, e_link);
    chk(msr_o == e_msr, "R10", "msr", msr_o, e_msr);
    chk(esr_we_o == wesr, "R9", "esr_we", 32'(esr_we_o), 32'(wesr));
    chk(esr_o == e_esr, (e_kind == 3) ? "R11" : "R7", "esr", esr_o, e_esr);
    chk(btr_we_o == wbtr, "R9", "btr_we", 32'(btr_we_o), 32'(wbtr));
    chk(btr_o == e_btr, "R9", "btr", btr_o, e_btr);
    chk(ear_we_o == wear, "R11", "ear_we", 32'(ear_we_o), 32'(wear));
    chk(ear_o == e_ear, "R11", "ear", ear_o, e_ear);
    chk(dbl_fault_o == m_dbl, "R12", "dbl_fault", 32'(dbl_fault_o), 32'(m_dbl));
  endtask

  task automatic mmu_case(input logic ds, input logic im, input logic bi);
    idle_inputs();
    fault_done_i = 1;
    step();
    idle_inputs();
    mmu_req_i = 1; dslot_i = ds; imm_i = im; bimm_i = bi;
    mmu_acc_i = 2; mmu_miss_i = 1;
    pc_i = 32'h0000_1000; btarget_i = 32'h0000_2468; mmu_addr_i = 32'hdead_0004;
    step(); // R8 return address corner
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    idle_inputs();
    pc_i = 0; btarget_i = 0; msr_i = 0; mmu_addr_i = 0;
    m_busy = 0; m_dbl = 0;
    e_kind = 0; e_pc = 0; e_link = 0; e_msr = 0; e_esr = 0; e_btr = 0; e_ear = 0; e_idx = 0;
    rst = 1;
    irq_req_i = 1; mmu_req_i = 1; msr_i = 32'h2;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(trap_taken_o == 0 && dbl_fault_o == 0 && pc_o == 0 && msr_o == 0 &&
        esr_we_o == 0 && btr_we_o == 0 && ear_we_o == 0 && link_data_o == 0,
        "R1", "reset outputs", pc_o, 32'h0);
    rst = 0;
    idle_inputs();
    step();

    // all four at once: fault wins (R2)
    msr_i = 32'h0000_2802;
    pc_i = 32'h40; mmu_req_i = 1; hwexc_req_i = 1; brk_req_i = 1; irq_req_i = 1;
    step();
    idle_inputs(); fault_done_i = 1; step();
    // exception over break and irq
    hwexc_req_i = 1; brk_req_i = 1; irq_req_i = 1; hwexc_cause_i = 5'd7; dslot_i = 1;
    btarget_i = 32'h1234_5678; step();
    idle_inputs(); brk_req_i = 1; irq_req_i = 1; step();
    // R3 interrupt gate, one blocker at a time
    idle_inputs(); irq_req_i = 1; msr_i = 32'h0000_0000; step();
    msr_i = 32'h0000_0202; step();
    msr_i = 32'h0000_0008 | 32'h2; step();
    msr_i = 32'h2; dslot_i = 1; step();
    dslot_i = 0; imm_i = 1; step();
    imm_i = 0; msr_i = 32'h0000_A002; step();

    // R8 corners
    mmu_case(1, 0, 1);
    mmu_case(1, 0, 0);
    mmu_case(0, 1, 0);
    mmu_case(0, 0, 0);
    // R11 codes
    idle_inputs(); fault_done_i = 1; step();
    idle_inputs(); mmu_req_i = 1; mmu_acc_i = 0; mmu_miss_i = 0; mmu_addr_i = 32'h10; step();
    idle_inputs(); fault_done_i = 1; step();
    idle_inputs(); mmu_req_i = 1; mmu_acc_i = 1; mmu_miss_i = 0; mmu_addr_i = 32'h20; step();
    idle_inputs(); fault_done_i = 1; step();
    idle_inputs(); mmu_req_i = 1; mmu_acc_i = 0; mmu_miss_i = 1; mmu_addr_i = 32'h30; step();
    idle_inputs(); fault_done_i = 1; mmu_req_i = 1; mmu_acc_i = 1; mmu_miss_i = 1; step();
    idle_inputs(); fault_done_i = 1; step();

    // random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      idle_inputs();
      pc_i = {$urandom} & 32'hFFFF_FFFC;
      btarget_i = $urandom;
      msr_i = $urandom;
      if (r[0]) msr_i[9] = 0;
      if (r[1]) msr_i[3] = 0;
      msr_i[1] = r[2] | r[3];
      hwexc_req_i = (r[7:4] == 0);
      brk_req_i = (r[11:8] == 0);
      irq_req_i = r[12];
      mmu_req_i = !m_busy && (r[15:13] == 0);
      mmu_miss_i = r[16];
      mmu_acc_i = r[18:17];
      if (mmu_acc_i == 3) mmu_acc_i = 1;
      mmu_addr_i = $urandom;
      hwexc_cause_i = r[23:19];
      case (r[25:24])
        2'd0: begin dslot_i = 1; bimm_i = r[26]; end
        2'd1: imm_i = 1;
        default: ;
      endcase
      fault_done_i = r[27];
      step();
    end

    // R12 double fault
    idle_inputs(); fault_done_i = 1; step();
    idle_inputs(); mmu_req_i = 1; pc_i = 32'h500; mmu_addr_i = 32'h77; step();
    idle_inputs(); mmu_req_i = 1; hwexc_req_i = 1; pc_i = 32'h600; step();
    idle_inputs(); irq_req_i = 1; msr_i = 32'h2; step();
    idle_inputs(); fault_done_i = 1; step();
    idle_inputs(); mmu_req_i = 1; mmu_addr_i = 32'h88; step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule